// File: doc/BRIEF.md
# Fetch Target Sequencer

This block sits between the fetch target queue of a decoupled branch predictor and the instruction fetch stage. For every hardware thread it tracks two things. The first is whether the current fetch target has run out. The second is whether the fetch buffer holds valid bytes that cover the PC being fetched. At the end of each fetch loop it decides whether a new instruction-cache request is due, and it produces the start address for that request. In decoupled mode the address comes from the head of the predictor's queue. In sequential mode it is the current PC.

The fetch stage tells the block when an instruction's prediction exhausts the current target, when a loop ends, and when a cache fill lands. The predictor reports each cycle whether it managed to supply a new target. A squash for a thread wipes that thread's state. A combinational stop signal tells the fetch loop when it must end the current cycle.

Top module: `fetch_target_seq`

## Requirements
- R1: During and after reset, every thread has its used-up flag clear, its buffer invalid and no request pending, and `req_valid_o` is low.
- R2: A predictor advance (`tick_i`) for a thread sets that thread's used-up flag when `supply_ok_i` is 0 and clears it when `supply_ok_i` is 1. The new value is visible one cycle later.
- R3: In decoupled mode (`mode_dec_i`=1), a loop end (`fetch_valid_i` and `loop_end_i`) requests a new target only when the flag is set or the buffer is invalid. If the request is made, `req_valid_o`, `req_tid_o` and `req_addr_o` show it on the next cycle.
- R4: If the flag is set at a decoupled loop end, the block first tries an immediate supply. If `head_ok_i` is 1, the request goes to `head_pc_i` and the flag clears. If `head_ok_i` is 0, no request is made and the flag stays set.
- R5: A target start address of zero means no entry is available. No request is issued in that case, and the flag is not cleared.
- R6: `exhaust_i` marks the thread's buffer invalid. In decoupled mode it also sets the flag. The loop-end decision in the same cycle already sees both effects.
- R7: In sequential mode (`mode_dec_i`=0), a loop end requests `fetch_pc_i` when any of these holds: the buffer is invalid, the PC lies below the buffer start, or PC+4 exceeds the buffer start plus `BUF_BYTES`.
- R8: `loop_stop_o` is high when any of these holds: a taken branch is predicted, `insts_done_i` reaches `FETCH_WIDTH`, the fetch queue is full, or the thread is in decoupled mode with its flag set.
- R9: After a request, no further request is made for that thread until a fill (`fill_i`) arrives. A fill marks the buffer valid from `fill_start_i`.
- R10: A squash for a thread clears its flag, its buffer and its pending request in the same cycle, and it suppresses any request that the thread's loop end would make in that cycle.
- R11: When a predictor advance and a loop end for the same thread fall in one cycle, the request is still issued, and the advance's outcome sets the flag.
- R12: All events change only the state of the thread they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dec_i | input | 1 | 1 = decoupled mode, 0 = sequential mode |
| tick_i | input | 1 | Predictor advanced this cycle |
| tick_tid_i | input | TID_W | Thread of the predictor advance |
| supply_ok_i | input | 1 | Predictor supplied a target on its advance |
| fetch_valid_i | input | 1 | Fetch stage active for `fetch_tid_i` |
| fetch_tid_i | input | TID_W | Thread being fetched |
| fetch_pc_i | input | AW | Current fetch PC |
| exhaust_i | input | 1 | A prediction exhausted the current target |
| loop_end_i | input | 1 | Fetch loop ends this cycle |
| br_taken_i | input | 1 | Predicted-taken branch seen |
| insts_done_i | input | CNT_W | Instructions fetched this cycle so far |
| fq_full_i | input | 1 | Fetch queue full |
| head_pc_i | input | AW | Start PC of the queue head, 0 if none |
| head_ok_i | input | 1 | Immediate supply of the next head succeeded |
| fill_i | input | 1 | Cache fill delivered into a buffer |
| fill_tid_i | input | TID_W | Thread of the fill |
| fill_start_i | input | AW | Start address of the filled buffer |
| squash_i | input | 1 | Squash a thread |
| squash_tid_i | input | TID_W | Thread squashed |
| loop_stop_o | output | 1 | Fetch loop must stop |
| req_valid_o | output | 1 | New cache request issued |
| req_tid_o | output | TID_W | Thread of the request |
| req_addr_o | output | AW | Start address of the request |
| used_up_o | output | THREADS | Per-thread used-up flag |
| buf_valid_o | output | THREADS | Per-thread buffer-valid bit |

## Verification
Two pairs of functions can collide in a single cycle. The first pair is the predictor advance and the loop-end decision on the same thread. The second pair is a squash and the loop-end decision on the same thread. The bench drives both events of a pair together from its vector table. For the first pair it judges the result by whether a request appears and by which value the flag holds one cycle later, and it expects the advance to win the flag. For the second pair it checks that the squash suppresses the request.

// File: rtl/ftseq_pkg.sv
package ftseq_pkg;
  typedef enum logic {
    FETCH_SEQ = 1'b0,
    FETCH_DEC = 1'b1
  } fetch_mode_e;

  typedef struct packed {
    logic used_up;
    logic buf_valid;
    logic pending;
  } slot_flags_t;
endpackage

// File: rtl/ftseq_stop_gate.sv
module ftseq_stop_gate #(
  parameter int FETCH_WIDTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             br_taken,
  input  logic [CNT_W-1:0] insts_done,
  input  logic             fq_full,
  input  logic             no_target,
  output logic             stop
);
  always_comb begin
    stop = br_taken || fq_full || no_target ||
           (insts_done >= CNT_W'(FETCH_WIDTH));
  end
endmodule

// File: rtl/ftseq_need_logic.sv
module ftseq_need_logic
  import ftseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int BUF_BYTES = 64
) (
  input  fetch_mode_e    mode,
  input  slot_flags_t    flags,
  input  logic [AW-1:0]  buf_start,
  input  logic [AW-1:0]  pc,
  input  logic           exhaust,
  input  logic [AW-1:0]  head_pc,
  input  logic           head_ok,
  output logic           want,
  output logic [AW-1:0]  addr,
  output logic           clr_flag
);
  localparam int EW = AW + 1;

  logic          uu_eff;
  logic          bv_eff;
  logic [EW-1:0] pc_end;
  logic [EW-1:0] buf_end;
  logic          out_of_range;

  always_comb begin
    uu_eff       = flags.used_up || (exhaust && mode == FETCH_DEC);
    bv_eff       = flags.buf_valid && !exhaust;
    pc_end       = {1'b0, pc} + EW'(4);
    buf_end      = {1'b0, buf_start} + EW'(BUF_BYTES);
    out_of_range = (pc < buf_start) || (pc_end > buf_end);
    want         = 1'b0;
    addr         = '0;
    clr_flag     = 1'b0;
    if (mode == FETCH_DEC) begin
      if (uu_eff) addr = head_ok ? head_pc : '0;
      else        addr = head_pc;
      want     = (uu_eff || !bv_eff) && (addr != '0);
      clr_flag = uu_eff && want;
    end else begin
      addr = pc;
      want = !bv_eff || out_of_range;
    end
  end
endmodule

// File: rtl/ftseq_thread_slot.sv
module ftseq_thread_slot
  import ftseq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           squash,
  input  logic           tick,
  input  logic           supply_ok,
  input  logic           exh_buf,
  input  logic           exh_flag,
  input  logic           fill,
  input  logic [AW-1:0]  fill_start,
  input  logic           issue,
  input  logic           clr_flag,
  output slot_flags_t    flags,
  output logic [AW-1:0]  buf_start
);
  slot_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (squash) begin
      nxt = '0;
    end else begin
      if (exh_flag) nxt.used_up = 1'b1;
      if (clr_flag) nxt.used_up = 1'b0;
      if (tick)     nxt.used_up = !supply_ok;
      if (exh_buf)  nxt.buf_valid = 1'b0;
      if (fill) begin
        nxt.buf_valid = 1'b1;
        nxt.pending   = 1'b0;
      end
      if (issue)    nxt.pending = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      buf_start <= '0;
    end else begin
      flags <= nxt;
      if (fill && !squash) buf_start <= fill_start;
    end
  end
endmodule

// File: rtl/fetch_target_seq.sv
module fetch_target_seq
  import ftseq_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int AW = 32,
  parameter int BUF_BYTES = 64,
  parameter int FETCH_WIDTH = 8,
  parameter int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  parameter int CNT_W = $clog2(FETCH_WIDTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_dec_i,
  input  logic               tick_i,
  input  logic [TID_W-1:0]   tick_tid_i,
  input  logic               supply_ok_i,
  input  logic               fetch_valid_i,
  input  logic [TID_W-1:0]   fetch_tid_i,
  input  logic [AW-1:0]      fetch_pc_i,
  input  logic               exhaust_i,
  input  logic               loop_end_i,
  input  logic               br_taken_i,
  input  logic [CNT_W-1:0]   insts_done_i,
  input  logic               fq_full_i,
  input  logic [AW-1:0]      head_pc_i,
  input  logic               head_ok_i,
  input  logic               fill_i,
  input  logic [TID_W-1:0]   fill_tid_i,
  input  logic [AW-1:0]      fill_start_i,
  input  logic               squash_i,
  input  logic [TID_W-1:0]   squash_tid_i,
  output logic               loop_stop_o,
  output logic               req_valid_o,
  output logic [TID_W-1:0]   req_tid_o,
  output logic [AW-1:0]      req_addr_o,
  output logic [THREADS-1:0] used_up_o,
  output logic [THREADS-1:0] buf_valid_o
);
  fetch_mode_e  mode;
  slot_flags_t  flags   [THREADS];
  logic [AW-1:0] starts [THREADS];

  slot_flags_t   cur_flags;
  logic [AW-1:0] cur_start;
  logic          want;
  logic [AW-1:0] dec_addr;
  logic          dec_clr;
  logic          issue;
  logic          fetch_exh;

  assign mode      = fetch_mode_e'(mode_dec_i);
  assign cur_flags = flags[fetch_tid_i];
  assign cur_start = starts[fetch_tid_i];
  assign fetch_exh = fetch_valid_i && exhaust_i;

  ftseq_need_logic #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_need (
    .mode      (mode),
    .flags     (cur_flags),
    .buf_start (cur_start),
    .pc        (fetch_pc_i),
    .exhaust   (fetch_exh),
    .head_pc   (head_pc_i),
    .head_ok   (head_ok_i),
    .want      (want),
    .addr      (dec_addr),
    .clr_flag  (dec_clr)
  );

  always_comb begin
    issue = fetch_valid_i && loop_end_i && want && !cur_flags.pending &&
            !(squash_i && squash_tid_i == fetch_tid_i);
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_slot
    logic is_fetch;
    assign is_fetch = (fetch_tid_i == TID_W'(t));

    ftseq_thread_slot #(.AW(AW)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .squash     (squash_i && squash_tid_i == TID_W'(t)),
      .tick       (tick_i && tick_tid_i == TID_W'(t)),
      .supply_ok  (supply_ok_i),
      .exh_buf    (fetch_exh && is_fetch),
      .exh_flag   (fetch_exh && is_fetch && mode == FETCH_DEC),
      .fill       (fill_i && fill_tid_i == TID_W'(t)),
      .fill_start (fill_start_i),
      .issue      (issue && is_fetch),
      .clr_flag   (issue && is_fetch && dec_clr),
      .flags      (flags[t]),
      .buf_start  (starts[t])
    );

    assign used_up_o[t]   = flags[t].used_up;
    assign buf_valid_o[t] = flags[t].buf_valid;
  end

  ftseq_stop_gate #(.FETCH_WIDTH(FETCH_WIDTH), .CNT_W(CNT_W)) u_stop (
    .br_taken   (br_taken_i),
    .insts_done (insts_done_i),
    .fq_full    (fq_full_i),
    .no_target  (mode == FETCH_DEC && cur_flags.used_up),
    .stop       (loop_stop_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_o <= 1'b0;
      req_tid_o   <= '0;
      req_addr_o  <= '0;
    end else begin
      req_valid_o <= issue;
      if (issue) begin
        req_tid_o  <= fetch_tid_i;
        req_addr_o <= dec_addr;
      end
    end
  end
endmodule

// File: rtl/fetch_target_seq_chk.sv
module fetch_target_seq_chk #(
  parameter int THREADS = 2,
  parameter int AW = 32,
  parameter int TID_W = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_dec_i,
  input logic               tick_i,
  input logic [TID_W-1:0]   tick_tid_i,
  input logic               supply_ok_i,
  input logic               squash_i,
  input logic [TID_W-1:0]   squash_tid_i,
  input logic               fetch_valid_i,
  input logic               loop_end_i,
  input logic [TID_W-1:0]   fetch_tid_i,
  input logic               req_valid_o,
  input logic [TID_W-1:0]   req_tid_o,
  input logic [AW-1:0]      req_addr_o,
  input logic [THREADS-1:0] used_up_o,
  input logic [THREADS-1:0] buf_valid_o
);
  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (!req_valid_o && used_up_o == '0 && buf_valid_o == '0));

  assert_tick_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !(squash_i && squash_tid_i == tick_tid_i))
      |=> (used_up_o[$past(tick_tid_i)] == !$past(supply_ok_i)));

  assert_no_zero_target_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_dec_i && fetch_valid_i && loop_end_i)
      |=> (!req_valid_o || req_addr_o != '0));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |=> !(req_valid_o && req_tid_o == $past(req_tid_o)));

  assert_squash_clear_R10: assert property (@(posedge clk) disable iff (rst)
    squash_i |=> (!used_up_o[$past(squash_tid_i)] &&
                  !buf_valid_o[$past(squash_tid_i)]));

  assert_squash_blocks_req_R10: assert property (@(posedge clk) disable iff (rst)
    (squash_i && fetch_valid_i && loop_end_i && squash_tid_i == fetch_tid_i)
      |=> !(req_valid_o && req_tid_o == $past(squash_tid_i)));
endmodule

bind fetch_target_seq fetch_target_seq_chk #(
  .THREADS (THREADS),
  .AW      (AW),
  .TID_W   (TID_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_dec_i    (mode_dec_i),
  .tick_i        (tick_i),
  .tick_tid_i    (tick_tid_i),
  .supply_ok_i   (supply_ok_i),
  .squash_i      (squash_i),
  .squash_tid_i  (squash_tid_i),
  .fetch_valid_i (fetch_valid_i),
  .loop_end_i    (loop_end_i),
  .fetch_tid_i   (fetch_tid_i),
  .req_valid_o   (req_valid_o),
  .req_tid_o     (req_tid_o),
  .req_addr_o    (req_addr_o),
  .used_up_o     (used_up_o),
  .buf_valid_o   (buf_valid_o)
);

// File: tb/test_fetch_target_seq.sv
module test_fetch_target_seq;
  localparam int THREADS = 2;
  localparam int AW = 32;
  localparam int BUF_BYTES = 64;
  localparam int FETCH_WIDTH = 8;
  localparam int TID_W = 1;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_dec_i = 1'b1, tick_i = 1'b0, supply_ok_i = 1'b0;
  logic [TID_W-1:0] tick_tid_i = '0, fetch_tid_i = '0, fill_tid_i = '0, squash_tid_i = '0;
  logic fetch_valid_i = 1'b0, exhaust_i = 1'b0, loop_end_i = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0, head_pc_i = '0, fill_start_i = '0;
  logic br_taken_i = 1'b0, fq_full_i = 1'b0, head_ok_i = 1'b0, fill_i = 1'b0, squash_i = 1'b0;
  logic [CNT_W-1:0] insts_done_i = '0;
  logic loop_stop_o, req_valid_o;
  logic [TID_W-1:0] req_tid_o;
  logic [AW-1:0] req_addr_o;
  logic [THREADS-1:0] used_up_o, buf_valid_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fetch_target_seq #(
    .THREADS(THREADS), .AW(AW), .BUF_BYTES(BUF_BYTES), .FETCH_WIDTH(FETCH_WIDTH)
  ) i_fetch_target_seq (
    .clk(clk), .rst(rst), .mode_dec_i(mode_dec_i), .tick_i(tick_i),
    .tick_tid_i(tick_tid_i), .supply_ok_i(supply_ok_i),
    .fetch_valid_i(fetch_valid_i), .fetch_tid_i(fetch_tid_i),
    .fetch_pc_i(fetch_pc_i), .exhaust_i(exhaust_i), .loop_end_i(loop_end_i),
    .br_taken_i(br_taken_i), .insts_done_i(insts_done_i), .fq_full_i(fq_full_i),
    .head_pc_i(head_pc_i), .head_ok_i(head_ok_i), .fill_i(fill_i),
    .fill_tid_i(fill_tid_i), .fill_start_i(fill_start_i), .squash_i(squash_i),
    .squash_tid_i(squash_tid_i), .loop_stop_o(loop_stop_o),
    .req_valid_o(req_valid_o), .req_tid_o(req_tid_o), .req_addr_o(req_addr_o),
    .used_up_o(used_up_o), .buf_valid_o(buf_valid_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        tick;
    logic        sup;
    logic        exh;
    logic        le;
    logic [31:0] pc;
    logic        fill;
    logic [31:0] fst;
    logic [31:0] head;
    logic        hok;
    logic        sq;
    logic        dec;
    logic        erv;
    logic [31:0] eaddr;
    logic        euu;
    logic        ebv;
  } vec_t;

  localparam int NV = 24;
  // Thread 0. Fields: req, tick, sup, exh, le, pc, fill, fst, head, hok, sq, dec, erv, eaddr, euu, ebv
  localparam vec_t VT [NV] = '{
    '{8'd3,  0,0,0,1, 32'h0,    0,32'h0,    32'h100,0, 0,1, 1,32'h100, 0,0}, // R3 invalid buffer
    '{8'd9,  0,0,0,1, 32'h0,    0,32'h0,    32'h200,0, 0,1, 0,32'h0,   0,0}, // R9 pending blocks
    '{8'd9,  0,0,0,0, 32'h0,    1,32'h100,  32'h0,  0, 0,1, 0,32'h0,   0,1}, // R9 fill
    '{8'd3,  0,0,0,1, 32'h0,    0,32'h0,    32'h300,0, 0,1, 0,32'h0,   0,1}, // R3 no need
    '{8'd2,  1,0,0,0, 32'h0,    0,32'h0,    32'h0,  0, 0,1, 0,32'h0,   1,1}, // R2 fail sets
    '{8'd4,  0,0,0,1, 32'h0,    0,32'h0,    32'h300,0, 0,1, 0,32'h0,   1,1}, // R4 immediate fails
    '{8'd4,  0,0,0,1, 32'h0,    0,32'h0,    32'h300,1, 0,1, 1,32'h300, 0,1}, // R4 immediate ok
    '{8'd9,  0,0,0,0, 32'h0,    1,32'h300,  32'h0,  0, 0,1, 0,32'h0,   0,1}, // R9
    '{8'd2,  1,0,0,0, 32'h0,    0,32'h0,    32'h0,  0, 0,1, 0,32'h0,   1,1}, // R2
    '{8'd2,  1,1,0,0, 32'h0,    0,32'h0,    32'h0,  0, 0,1, 0,32'h0,   0,1}, // R2 success clears
    '{8'd6,  0,0,1,1, 32'h0,    0,32'h0,    32'h400,1, 0,1, 1,32'h400, 0,0}, // R6 exhaust seen same cycle
    '{8'd9,  0,0,0,0, 32'h0,    1,32'h400,  32'h0,  0, 0,1, 0,32'h0,   0,1}, // R9
    '{8'd6,  0,0,1,0, 32'h0,    0,32'h0,    32'h0,  0, 0,1, 0,32'h0,   1,0}, // R6 exhaust alone
    '{8'd5,  0,0,0,1, 32'h0,    0,32'h0,    32'h0,  1, 0,1, 0,32'h0,   1,0}, // R5 zero head
    '{8'd11, 1,0,0,1, 32'h0,    0,32'h0,    32'h500,1, 0,1, 1,32'h500, 1,0}, // R11 tick wins flag
    '{8'd10, 0,0,0,0, 32'h0,    0,32'h0,    32'h0,  0, 1,1, 0,32'h0,   0,0}, // R10 squash clears
    '{8'd10, 0,0,0,1, 32'h0,    0,32'h0,    32'h600,0, 1,1, 0,32'h0,   0,0}, // R10 squash blocks
    '{8'd7,  0,0,0,1, 32'h1000, 0,32'h0,    32'h0,  0, 0,0, 1,32'h1000,0,0}, // R7 invalid
    '{8'd9,  0,0,0,0, 32'h0,    1,32'h1000, 32'h0,  0, 0,0, 0,32'h0,   0,1}, // R9
    '{8'd7,  0,0,0,1, 32'h103C, 0,32'h0,    32'h0,  0, 0,0, 0,32'h0,   0,1}, // R7 last word fits
    '{8'd7,  0,0,0,1, 32'h103D, 0,32'h0,    32'h0,  0, 0,0, 1,32'h103D,0,1}, // R7 past end
    '{8'd9,  0,0,0,0, 32'h0,    1,32'h1000, 32'h0,  0, 0,0, 0,32'h0,   0,1}, // R9
    '{8'd7,  0,0,0,1, 32'h0FFC, 0,32'h0,    32'h0,  0, 0,0, 1,32'h0FFC,0,1}, // R7 below start
    '{8'd9,  0,0,0,1, 32'h2000, 0,32'h0,    32'h0,  0, 0,0, 0,32'h0,   0,1}  // R9 still pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tick_i = 0; supply_ok_i = 0; fetch_valid_i = 0; exhaust_i = 0; loop_end_i = 0;
    fill_i = 0; squash_i = 0; head_ok_i = 0; head_pc_i = '0; br_taken_i = 0;
    fq_full_i = 0; insts_done_i = '0; tick_tid_i = '0; fetch_tid_i = '0;
    fill_tid_i = '0; squash_tid_i = '0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req_valid", 32'(req_valid_o), 0);
    chk("R1 used_up", 32'(used_up_o), 0);
    chk("R1 buf_valid", 32'(buf_valid_o), 0);
    @(negedge clk) rst = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      tick_i = VT[i].tick; supply_ok_i = VT[i].sup; exhaust_i = VT[i].exh;
      loop_end_i = VT[i].le; fetch_valid_i = VT[i].exh | VT[i].le;
      fetch_pc_i = VT[i].pc; fill_i = VT[i].fill; fill_start_i = VT[i].fst;
      head_pc_i = VT[i].head; head_ok_i = VT[i].hok; squash_i = VT[i].sq;
      mode_dec_i = VT[i].dec;
      @(posedge clk); #1;
      chk($sformatf("R%0d vec%0d req_valid", VT[i].req, i), 32'(req_valid_o), 32'(VT[i].erv));
      if (VT[i].erv)
        chk($sformatf("R%0d vec%0d req_addr", VT[i].req, i), req_addr_o, VT[i].eaddr);
      chk($sformatf("R%0d vec%0d used_up", VT[i].req, i), 32'(used_up_o[0]), 32'(VT[i].euu));
      chk($sformatf("R%0d vec%0d buf_valid", VT[i].req, i), 32'(buf_valid_o[0]), 32'(VT[i].ebv));
    end

    // R8 loop stop conditions, thread 0 has a clear flag here
    @(negedge clk); idle(); mode_dec_i = 1;
    #1 chk("R8 quiet", 32'(loop_stop_o), 0);
    br_taken_i = 1; #1 chk("R8 taken", 32'(loop_stop_o), 1); br_taken_i = 0;
    insts_done_i = CNT_W'(FETCH_WIDTH - 1); #1 chk("R8 width-1", 32'(loop_stop_o), 0);
    insts_done_i = CNT_W'(FETCH_WIDTH); #1 chk("R8 width", 32'(loop_stop_o), 1);
    insts_done_i = '0; fq_full_i = 1; #1 chk("R8 queue full", 32'(loop_stop_o), 1);
    fq_full_i = 0;

    // R12 thread isolation: advance fails on thread 1 only
    tick_i = 1; tick_tid_i = 1'b1; supply_ok_i = 0;
    @(posedge clk); #1;
    chk("R12 thread1 flag", 32'(used_up_o[1]), 1);
    chk("R12 thread0 flag", 32'(used_up_o[0]), 0);
    @(negedge clk); idle(); fetch_tid_i = 1'b1; mode_dec_i = 1;
    #1 chk("R8 no target", 32'(loop_stop_o), 1);
    mode_dec_i = 0; #1 chk("R8 sequential ignores flag", 32'(loop_stop_o), 0);
    mode_dec_i = 1;
    squash_i = 1; squash_tid_i = 1'b1;
    @(posedge clk); #1;
    chk("R12 squash thread1 flag", 32'(used_up_o[1]), 0);
    chk("R12 thread0 buffer kept", 32'(buf_valid_o[0]), 1);
    @(negedge clk); idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule